// File: doc/BRIEF.md
# Dual-Channel Converter Serial Load Controller

This block is the digital front end of a two-channel 12-bit converter. A host shifts a 16-bit command word in over a three-wire serial link (serial clock, serial data and an active-low select) and then commits the 12-bit data field of that word to the channel A register, the channel B register, or both. The two channel registers drive the converter core directly. They hold unipolar straight-binary codes, so code 0 is zero scale, 2048 is mid-scale and 4095 is full scale.

Two commit styles are chosen per word by its top bit. In strobe-steered mode, each channel has its own active-low load pin and the pin that falls picks the channel. In address-steered mode, the two load pins merge into one trigger and two address bits in the word pick the channel. All serial and strobe pins are asynchronous to the system clock. They are synchronised inside the block, and every commit happens exactly once, on a strobe's falling edge.

Top module: `dacSerialLoad`

## Requirements
- R1: The input register shifts one bit in, MSB first, on each rising edge of `serClk` while `selN` is low. While `selN` is high, `serClk` activity leaves the register unchanged.
- R2: Word layout: bit 15 is the mode bit (0 = strobe-steered, 1 = address-steered), bit 14 is address A, bit 13 is address B, bit 12 is ignored, and bits 11..0 are the data field.
- R3: In strobe-steered mode, a falling edge on `loadAN` alone copies the data field into `chanA` and leaves `chanB` unchanged.
- R4: In strobe-steered mode, a falling edge on `loadBN` alone copies the data field into `chanB` and leaves `chanA` unchanged.
- R5: In strobe-steered mode, falling edges on both pins together load the data field into both channels.
- R6: In address-steered mode, a falling edge on either load pin (the pins merged into one active-low trigger) loads the data field by address. A=1,B=0 loads `chanA`, A=0,B=1 loads `chanB`, and A=1,B=1 loads both.
- R7: In address-steered mode with A=0,B=0, a trigger changes neither channel.
- R8: Each falling edge commits once. A strobe held low does not commit again when the input register changes, and its rising edge commits nothing.
- R9: Reset clears both channel registers to 0x000 and the input register to all zeros.
- R10: The data field reaches the channel register unchanged across the full straight-binary range, including 0x000, 0x800 and 0xFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial shift clock, asynchronous |
| serData | input | 1 | Serial data, sampled on serClk rising edge |
| selN | input | 1 | Active-low serial select |
| loadAN | input | 1 | Active-low load strobe A |
| loadBN | input | 1 | Active-low load strobe B |
| chanA | output | 12 | Channel A code register |
| chanB | output | 12 | Channel B code register |

## Verification
The embedded assertions watch, on every cycle, that the input register moves only on a shift command, that a channel register moves only when its load command fires and then takes the data field of the preceding cycle, that a load command never repeats on consecutive cycles, and that a null address never produces a load. Only the directed scenarios can show the end-to-end mapping: pin edges through the synchronisers to the right channel, bit ordering and the ignored bit, the merged trigger driven from a single pin, deselected serial clocks, a held strobe, and the input register cleared by reset as seen through a partial word.

// File: rtl/dacLoadPkg.sv
package dacLoadPkg;
  // Command strobes from the control to the datapath, one system cycle wide
  typedef struct packed {
    logic shiftEn;  // shift serBit into the input register
    logic serBit;   // synchronised serial data bit
    logic loadA;    // commit data field to channel A
    logic loadB;    // commit data field to channel B
  } loadCmd_t;
endpackage

// File: rtl/dacSync.sv
module dacSync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= {STAGES{RESET_VAL}};
    else       pipe <= {pipe[STAGES-2:0], dIn};
  end

  assign dOut = pipe[STAGES-1];
endmodule

// File: rtl/dacLoadCtrl.sv
module dacLoadCtrl
  import dacLoadPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     serClk,
  input  logic     serData,
  input  logic     selN,
  input  logic     loadAN,
  input  logic     loadBN,
  input  logic     modeBit,
  input  logic     addrA,
  input  logic     addrB,
  output loadCmd_t cmd
);
  localparam int NSIG = 5;
  localparam logic [NSIG-1:0] IDLE_VALS = 5'b11100;

  logic [NSIG-1:0] rawPins;
  logic [NSIG-1:0] syncPins;

  assign rawPins = {loadBN, loadAN, selN, serData, serClk};

  for (genvar i = 0; i < NSIG; i++) begin : gSync
    dacSync #(.STAGES(SYNC_STAGES), .RESET_VAL(IDLE_VALS[i])) uSync (
      .clk (clk),
      .rstN(rstN),
      .dIn (rawPins[i]),
      .dOut(syncPins[i])
    );
  end

  logic sClk, sData, sSel, sA, sB, sMerged;
  assign sClk    = syncPins[0];
  assign sData   = syncPins[1];
  assign sSel    = syncPins[2];
  assign sA      = syncPins[3];
  assign sB      = syncPins[4];
  assign sMerged = sA & sB;  // low while either strobe is low

  logic clkPrev, aPrev, bPrev, mergedPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev    <= 1'b0;
      aPrev      <= 1'b1;
      bPrev      <= 1'b1;
      mergedPrev <= 1'b1;
    end else begin
      clkPrev    <= sClk;
      aPrev      <= sA;
      bPrev      <= sB;
      mergedPrev <= sMerged;
    end
  end

  logic fallA, fallB, fallMerged;
  assign fallA      = aPrev & ~sA;
  assign fallB      = bPrev & ~sB;
  assign fallMerged = mergedPrev & ~sMerged;

  always_comb begin
    cmd.shiftEn = ~clkPrev & sClk & ~sSel;
    cmd.serBit  = sData;
    if (modeBit) begin
      cmd.loadA = fallMerged & addrA;
      cmd.loadB = fallMerged & addrB;
    end else begin
      cmd.loadA = fallA;
      cmd.loadB = fallB;
    end
  end

  AST_NULL_ADDR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (modeBit && !addrA && !addrB) |-> !(cmd.loadA || cmd.loadB)); // R7
  AST_ONE_SHOT_A: assert property (@(posedge clk) disable iff (!rstN)
    cmd.loadA |=> !cmd.loadA); // R8
  AST_ONE_SHOT_B: assert property (@(posedge clk) disable iff (!rstN)
    cmd.loadB |=> !cmd.loadB); // R8
endmodule

// File: rtl/dacLoadPath.sv
module dacLoadPath
  import dacLoadPkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  loadCmd_t          cmd,
  output logic              modeBit,
  output logic              addrA,
  output logic              addrB,
  output logic [DATA_W-1:0] chanA,
  output logic [DATA_W-1:0] chanB
);
  localparam int MODE_POS  = WORD_W - 1;
  localparam int ADDRA_POS = WORD_W - 2;
  localparam int ADDRB_POS = WORD_W - 3;

  logic [WORD_W-1:0] shiftReg;
  logic [DATA_W-1:0] dataField;

  assign dataField = shiftReg[DATA_W-1:0];
  assign modeBit   = shiftReg[MODE_POS];
  assign addrA     = shiftReg[ADDRA_POS];
  assign addrB     = shiftReg[ADDRB_POS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            shiftReg <= '0;
    else if (cmd.shiftEn) shiftReg <= {shiftReg[WORD_W-2:0], cmd.serBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanA <= '0;
      chanB <= '0;
    end else begin
      if (cmd.loadA) chanA <= dataField;
      if (cmd.loadB) chanB <= dataField;
    end
  end

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.shiftEn |=> $stable(shiftReg)); // R1
  AST_HOLD_A: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.loadA |=> $stable(chanA)); // R8
  AST_HOLD_B: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.loadB |=> $stable(chanB)); // R8
  AST_LOAD_A: assert property (@(posedge clk) disable iff (!rstN)
    cmd.loadA |=> chanA == $past(shiftReg[DATA_W-1:0])); // R3
  AST_LOAD_B: assert property (@(posedge clk) disable iff (!rstN)
    cmd.loadB |=> chanB == $past(shiftReg[DATA_W-1:0])); // R4
endmodule

// File: rtl/dacSerialLoad.sv
module dacSerialLoad
  import dacLoadPkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              selN,
  input  logic              loadAN,
  input  logic              loadBN,
  output logic [DATA_W-1:0] chanA,
  output logic [DATA_W-1:0] chanB
);
  loadCmd_t cmd;
  logic     modeBit, addrA, addrB;

  dacLoadCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .serClk (serClk),
    .serData(serData),
    .selN   (selN),
    .loadAN (loadAN),
    .loadBN (loadBN),
    .modeBit(modeBit),
    .addrA  (addrA),
    .addrB  (addrB),
    .cmd    (cmd)
  );

  dacLoadPath #(.WORD_W(WORD_W), .DATA_W(DATA_W)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .modeBit(modeBit),
    .addrA  (addrA),
    .addrB  (addrB),
    .chanA  (chanA),
    .chanB  (chanB)
  );
endmodule

// File: tb/sim_dacSerialLoad.sv
`timescale 1ns/1ps
module sim_dacSerialLoad;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic selN = 1'b1;
  logic loadAN = 1'b1;
  logic loadBN = 1'b1;
  logic [11:0] chanA, chanB;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dacSerialLoad u0 (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .selN(selN), .loadAN(loadAN), .loadBN(loadBN),
    .chanA(chanA), .chanB(chanB)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
    end
  endtask

  task automatic clockBits(input logic [15:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      serData = w[i];
      serClk  = 1'b0;
      waitCyc(3);
      serClk = 1'b1;
      waitCyc(3);
    end
    serClk = 1'b0;
    waitCyc(3);
  endtask

  task automatic sendBits(input logic [15:0] w, input int n);
    @(negedge clk);
    selN = 1'b0;
    waitCyc(3);
    clockBits(w, n);
    selN = 1'b1;
    waitCyc(4);
  endtask

  task automatic strobe(input bit a, input bit b);
    @(negedge clk);
    if (a) loadAN = 1'b0;
    if (b) loadBN = 1'b0;
    waitCyc(6);
    loadAN = 1'b1;
    loadBN = 1'b1;
    waitCyc(6);
  endtask

  task automatic pulseReset();
    @(negedge clk);
    rstN = 1'b0;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(3);
  endtask

  task automatic testReset();
    check("R9 reset chanA", chanA, 12'h000);
    check("R9 reset chanB", chanB, 12'h000);
  endtask

  task automatic testHwSingle();
    sendBits(16'h0123, 16);
    strobe(1, 0);
    check("R3 hw A loads A", chanA, 12'h123);
    check("R3 hw A leaves B", chanB, 12'h000);
    sendBits(16'h0ABC, 16);
    strobe(0, 1);
    check("R4 hw B loads B", chanB, 12'hABC);
    check("R4 hw B leaves A", chanA, 12'h123);
  endtask

  task automatic testHwBoth();
    sendBits(16'h0800, 16);
    strobe(1, 1);
    check("R5 hw both A mid-scale R10", chanA, 12'h800);
    check("R5 hw both B mid-scale R10", chanB, 12'h800);
  endtask

  task automatic testSoftware();
    sendBits(16'hCFFF, 16);  // mode 1, A=1, B=0, full scale
    strobe(0, 1);            // trigger from the B pin only
    check("R6 sw addr A via B pin, R10 full scale", chanA, 12'hFFF);
    check("R6 sw addr A leaves B", chanB, 12'h800);
    sendBits(16'hA456, 16);  // mode 1, A=0, B=1
    strobe(1, 0);
    check("R6 sw addr B via A pin", chanB, 12'h456);
    check("R6 sw addr B leaves A", chanA, 12'hFFF);
    sendBits(16'hE000, 16);  // both, zero scale
    strobe(1, 1);
    check("R6 sw both A, R10 zero", chanA, 12'h000);
    check("R6 sw both B, R10 zero", chanB, 12'h000);
    sendBits(16'hF321, 16);  // bit 12 set, must be ignored
    strobe(1, 0);
    check("R2 ignored bit A", chanA, 12'h321);
    check("R2 ignored bit B", chanB, 12'h321);
  endtask

  task automatic testNullAddr();
    sendBits(16'h8777, 16);
    strobe(1, 1);
    check("R7 null addr A", chanA, 12'h321);
    check("R7 null addr B", chanB, 12'h321);
  endtask

  task automatic testDeselected();
    sendBits(16'h0555, 16);
    clockBits(16'hFFFF, 16);  // selN stays high
    strobe(1, 0);
    check("R1 deselected clocks ignored", chanA, 12'h555);
  endtask

  task automatic testHeld();
    sendBits(16'h0111, 16);
    @(negedge clk);
    loadAN = 1'b0;
    waitCyc(6);
    check("R8 held first commit", chanA, 12'h111);
    sendBits(16'h0222, 16);
    check("R8 held no recommit", chanA, 12'h111);
    loadAN = 1'b1;
    waitCyc(6);
    check("R8 rising edge no commit", chanA, 12'h111);
    strobe(1, 0);
    check("R8 next edge commits", chanA, 12'h222);
  endtask

  task automatic testResetShift();
    pulseReset();
    check("R9 mid-run reset chanA", chanA, 12'h000);
    check("R9 mid-run reset chanB", chanB, 12'h000);
    sendBits(16'h000F, 4);
    strobe(1, 0);
    check("R9 input register cleared", chanA, 12'h00F);
  endtask

  initial begin
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(3);
    testReset();
    testHwSingle();
    testHwBoth();
    testSoftware();
    testNullAddr();
    testDeselected();
    testHeld();
    testResetShift();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule